// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block carries out a single DisplayPort AUX request for a host. The host presents a command type, a target address, a byte count between 1 and 16 and, for write commands, the payload. The controller first waits for the channel to stop being busy with an earlier transfer. It then requests ownership of the channel and waits for the grant. It confirms that a sink is attached and drives the request through an abstract AUX PHY interface.

A failed attempt is repeated after a long pause, up to a fixed attempt limit. When the transaction ends, the controller gives up ownership. It then raises a one-cycle completion pulse with a 2-bit result. For a successful read, the controller also returns the received bytes. All waits are counted in microseconds. The microsecond is built from a clock-per-microsecond parameter, so short values can be used in tests.

Result encoding: 0 = ok, 1 = busy, 2 = no sink, 3 = remote error. A command with bit 0 set is a read. A command with bit 0 clear is a write. Payload byte i sits at bits 8i+7:8i of the 128-bit data buses.

Top module: `aux_txn_ctrl`

## Requirements
- R1: While reset is held and after it is released, done, own_req, phy_start and phy_reset are low and rdata is zero.
- R2: If phy_busy stays high for IDLE_US microseconds, the transaction ends with result 1 (busy) and never asserts own_req or phy_start.
- R3: If own_grant does not answer own_req within GRANT_US microseconds, the transaction ends with result 1 (busy), own_req drops, and phy_start is never asserted.
- R4: If sink_present is low once ownership is granted, the transaction ends with result 2 (no sink) and phy_start is never asserted.
- R5: For a write, phy_wdata carries the first len payload bytes at their byte positions with all higher bytes zero. phy_len_m1 equals len-1, and phy_cmd and phy_addr equal the request.
- R6: For a read, phy_wdata is all zero. On success, rdata takes the first len bytes of phy_rdata with the higher bytes zero. A write leaves rdata unchanged.
- R7: Each attempt raises phy_reset for one cycle before phy_start. On the first attempt, phy_start follows phy_reset on the next cycle. On every later attempt, phy_start comes at least GAP_US microseconds after phy_reset.
- R8: An attempt whose phy_done arrives with phy_err low ends the transaction with result 0 (ok).
- R9: An attempt whose phy_done arrives with phy_err high is retried. After MAX_TRIES failed attempts, the transaction ends with result 3 (remote error), having issued exactly MAX_TRIES phy_start pulses.
- R10: If phy_done does not arrive within REQ_US microseconds of phy_start, the transaction ends at once with result 3 and no further attempt.
- R11: done is a single-cycle pulse. own_req is low while done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start pulse, accepted when the controller is idle |
| req_cmd | input | CMD_W | Command type, bit 0 set means read |
| req_addr | input | ADDR_W | Target address |
| req_len | input | LEN_W | Byte count, 1 to NBYTES |
| req_wdata | input | 8*NBYTES | Write payload |
| done | output | 1 | Completion pulse |
| result | output | 2 | Result code, valid with done |
| rdata | output | 8*NBYTES | Read bytes from the last successful read |
| phy_busy | input | 1 | Channel still busy with an earlier transfer |
| own_req | output | 1 | Channel ownership request |
| own_grant | input | 1 | Channel ownership grant |
| sink_present | input | 1 | A sink is attached |
| phy_reset | output | 1 | Pulse that clears the PHY request logic |
| phy_start | output | 1 | Pulse that launches one attempt |
| phy_cmd | output | CMD_W | Command for the PHY |
| phy_addr | output | ADDR_W | Address for the PHY |
| phy_len_m1 | output | LM1_W | Byte count minus one |
| phy_wdata | output | 8*NBYTES | Packed write payload |
| phy_done | input | 1 | Attempt finished |
| phy_err | input | 1 | Reply or error status non-zero, valid with phy_done |
| phy_rdata | input | 8*NBYTES | Received bytes, valid with phy_done |

## Verification
The bench covers several corner cases, and each one catches a specific kind of faulty design:
- **Attempt limit.** Every attempt is made to fail until the limit is reached. A controller with an off-by-one in its counter gives up one attempt early or late, and the count of phy_start pulses exposes it.
- **Stuck PHY.** A PHY that never answers must end the transaction after one attempt. A design that treats a missing reply as a retryable error would start a second attempt.
- **Retry pause.** The pause before a retry is measured. A design that waits before the first attempt, or skips the pause on retries, shows the wrong distance between phy_reset and phy_start.
- **Byte lengths.** Lengths of 1 and 16 are tested along with random lengths in between. An error in the byte mask would leak stale bytes past the length, or would load payload into a read.
- **Early exits.** The busy, ungranted and no-sink exits are each tested on their own. These would catch a controller that still starts an attempt, holds ownership after done, or reports the wrong code.

// File: rtl/aux_txn_pkg.sv
package aux_txn_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT_IDLE,
    S_WAIT_GRANT,
    S_CHK_SINK,
    S_PHY_RST,
    S_GAP,
    S_ISSUE,
    S_WAIT_DONE,
    S_FINISH
  } txn_state_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_BUSY   = 2'd1,
    RES_NOSINK = 2'd2,
    RES_REMOTE = 2'd3
  } txn_res_e;

endpackage

// File: rtl/aux_byte_mask.sv
// Byte-enable mask: byte i is all ones when i < len.
module aux_byte_mask #(
  parameter int NBYTES = 16,
  parameter int LEN_W  = 5
) (
  input  logic [LEN_W-1:0]    len,
  output logic [NBYTES*8-1:0] mask
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign mask[8*i +: 8] = (len > LEN_W'(i)) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/aux_us_timer.sv
// Microsecond timer: cleared on request, counts to a limit and holds.
module aux_us_timer #(
  parameter int CLK_PER_US = 100,
  parameter int US_W       = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [US_W-1:0] limit_us,
  output logic            expired
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [US_W-1:0]  us_q, us_d;
  logic             cnt_en;

  assign expired = (us_q >= limit_us);
  assign cnt_en  = clr | ~expired;

  always_comb begin
    pre_d = pre_q;
    us_d  = us_q;
    if (clr) begin
      pre_d = '0;
      us_d  = '0;
    end else if (pre_q == PRE_W'(CLK_PER_US - 1)) begin
      pre_d = '0;
      us_d  = us_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (cnt_en) begin
      pre_q <= pre_d;
      us_q  <= us_d;
    end
  end
endmodule

// File: rtl/aux_txn_ctrl.sv
module aux_txn_ctrl
  import aux_txn_pkg::*;
#(
  parameter int NBYTES     = 16,
  parameter int CMD_W      = 4,
  parameter int ADDR_W     = 20,
  parameter int CLK_PER_US = 100,
  parameter int IDLE_US    = 1000,
  parameter int GRANT_US   = 1000,
  parameter int REQ_US     = 1000,
  parameter int GAP_US     = 400,
  parameter int MAX_TRIES  = 32,
  localparam int DATA_W    = NBYTES * 8,
  localparam int LEN_W     = $clog2(NBYTES + 1),
  localparam int LM1_W     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [1:0]        result,
  output logic [DATA_W-1:0] rdata,
  input  logic              phy_busy,
  output logic              own_req,
  input  logic              own_grant,
  input  logic              sink_present,
  output logic              phy_reset,
  output logic              phy_start,
  output logic [CMD_W-1:0]  phy_cmd,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [LM1_W-1:0]  phy_len_m1,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_done,
  input  logic              phy_err,
  input  logic [DATA_W-1:0] phy_rdata
);
  localparam int US_MAX_A = (IDLE_US > GRANT_US) ? IDLE_US : GRANT_US;
  localparam int US_MAX_B = (REQ_US > GAP_US) ? REQ_US : GAP_US;
  localparam int US_MAX   = (US_MAX_A > US_MAX_B) ? US_MAX_A : US_MAX_B;
  localparam int US_W     = $clog2(US_MAX + 1);
  localparam int TRY_W    = $clog2(MAX_TRIES + 1);

  txn_state_e        st_q, st_d;
  txn_res_e          res_q, res_d;
  logic [TRY_W-1:0]  tries_q, tries_d;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, byte_en;
  logic              cap_en, rd_load, is_read;
  logic              tmr_clr, tmr_exp;
  logic [US_W-1:0]   tmr_lim;

  assign is_read = cmd_q[0];
  assign cap_en  = (st_q == S_IDLE) & req_valid;
  assign tmr_clr = (st_d != st_q);

  aux_byte_mask #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_mask (
    .len  (len_q),
    .mask (byte_en)
  );

  always_comb begin
    case (st_q)
      S_WAIT_IDLE:  tmr_lim = US_W'(IDLE_US);
      S_WAIT_GRANT: tmr_lim = US_W'(GRANT_US);
      S_GAP:        tmr_lim = US_W'(GAP_US);
      default:      tmr_lim = US_W'(REQ_US);
    endcase
  end

  aux_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .limit_us (tmr_lim),
    .expired  (tmr_exp)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    res_d   = res_q;
    tries_d = tries_q;
    rd_load = 1'b0;
    case (st_q)
      S_IDLE:
        if (req_valid) st_d = S_WAIT_IDLE;
      S_WAIT_IDLE:
        if (!phy_busy) begin
          st_d = S_WAIT_GRANT;
        end else if (tmr_exp) begin
          st_d  = S_FINISH;
          res_d = RES_BUSY;
        end
      S_WAIT_GRANT:
        if (own_grant) begin
          st_d = S_CHK_SINK;
        end else if (tmr_exp) begin
          st_d  = S_FINISH;
          res_d = RES_BUSY;
        end
      S_CHK_SINK:
        if (!sink_present) begin
          st_d  = S_FINISH;
          res_d = RES_NOSINK;
        end else begin
          st_d    = S_PHY_RST;
          tries_d = '0;
        end
      S_PHY_RST:
        st_d = (tries_q == '0) ? S_ISSUE : S_GAP;
      S_GAP:
        if (tmr_exp) st_d = S_ISSUE;
      S_ISSUE:
        st_d = S_WAIT_DONE;
      S_WAIT_DONE:
        if (phy_done) begin
          if (!phy_err) begin
            st_d    = S_FINISH;
            res_d   = RES_OK;
            rd_load = is_read;
          end else if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
            st_d  = S_FINISH;
            res_d = RES_REMOTE;
          end else begin
            st_d    = S_PHY_RST;
            tries_d = tries_q + 1'b1;
          end
        end else if (tmr_exp) begin
          st_d  = S_FINISH;
          res_d = RES_REMOTE;
        end
      S_FINISH:
        st_d = S_IDLE;
      default:
        st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      res_q   <= RES_OK;
      tries_q <= '0;
    end else begin
      st_q    <= st_d;
      res_q   <= res_d;
      tries_q <= tries_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      cmd_q   <= req_cmd;
      addr_q  <= req_addr;
      len_q   <= req_len;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_load) begin
      rdata_q <= phy_rdata & byte_en;
    end
  end

  assign own_req    = (st_q == S_WAIT_GRANT) | (st_q == S_CHK_SINK) |
                      (st_q == S_PHY_RST) | (st_q == S_GAP) |
                      (st_q == S_ISSUE) | (st_q == S_WAIT_DONE);
  assign done       = (st_q == S_FINISH);
  assign result     = res_q;
  assign rdata      = rdata_q;
  assign phy_reset  = (st_q == S_PHY_RST);
  assign phy_start  = (st_q == S_ISSUE);
  assign phy_cmd    = cmd_q;
  assign phy_addr   = addr_q;
  assign phy_len_m1 = LM1_W'(len_q - 1'b1);
  assign phy_wdata  = is_read ? '0 : (wdata_q & byte_en);

endmodule

// File: rtl/aux_txn_chk.sv
module aux_txn_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [1:0]        result,
  input logic [DATA_W-1:0] rdata,
  input logic              own_req,
  input logic              sink_present,
  input logic              phy_reset,
  input logic              phy_start,
  input logic              phy_done,
  input logic              phy_err
);
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_release_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !own_req);

  p_start_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phy_start |-> (own_req && !phy_reset));

  p_reset_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phy_reset |=> !phy_reset);

  p_ok_needs_clean_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd0) |-> $past(phy_done && !phy_err));

  p_nosink_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd2) |-> $past(!sink_present));

  p_rdata_moves_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);
endmodule

bind aux_txn_ctrl aux_txn_chk #(.DATA_W(DATA_W)) u_txn_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done         (done),
  .result       (result),
  .rdata        (rdata),
  .own_req      (own_req),
  .sink_present (sink_present),
  .phy_reset    (phy_reset),
  .phy_start    (phy_start),
  .phy_done     (phy_done),
  .phy_err      (phy_err)
);

// File: tb/test_aux_txn_ctrl.sv
module test_aux_txn_ctrl;
  localparam int CPU   = 2;
  localparam int IDLE  = 8;
  localparam int GRANT = 8;
  localparam int REQ   = 10;
  localparam int GAP   = 4;
  localparam int TRIES = 32;

  logic         clk, rst_n;
  logic         req_valid;
  logic [3:0]   req_cmd;
  logic [19:0]  req_addr;
  logic [4:0]   req_len;
  logic [127:0] req_wdata;
  logic         done;
  logic [1:0]   result;
  logic [127:0] rdata;
  logic         phy_busy, own_req, own_grant, sink_present;
  logic         phy_reset, phy_start;
  logic [3:0]   phy_cmd;
  logic [19:0]  phy_addr;
  logic [3:0]   phy_len_m1;
  logic [127:0] phy_wdata;
  logic         phy_done, phy_err;
  logic [127:0] phy_rdata;
  logic         grant_en;

  assign own_grant = own_req & grant_en;

  aux_txn_ctrl #(
    .CLK_PER_US(CPU), .IDLE_US(IDLE), .GRANT_US(GRANT),
    .REQ_US(REQ), .GAP_US(GAP), .MAX_TRIES(TRIES)
  ) i_aux_txn_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .done(done), .result(result), .rdata(rdata), .phy_busy(phy_busy),
    .own_req(own_req), .own_grant(own_grant), .sink_present(sink_present),
    .phy_reset(phy_reset), .phy_start(phy_start), .phy_cmd(phy_cmd),
    .phy_addr(phy_addr), .phy_len_m1(phy_len_m1), .phy_wdata(phy_wdata),
    .phy_done(phy_done), .phy_err(phy_err), .phy_rdata(phy_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchecks = 0, nfail = 0;
  int cyc = 0, last_rst = 0, starts = 0, first_gap = -1, min_gap = 0;
  int fail_left = 0, lat = 0;
  bit hang = 0, pend = 0, own_seen = 0, done_long = 0;
  logic [127:0] cap_wdata;
  logic [3:0]   cap_lm1, cap_cmd;
  logic [19:0]  cap_addr;
  logic [1:0]   got_res;
  logic [127:0] got_rdata;
  int           got_cyc;

  // PHY and monitor model, evaluated away from the active edge
  always @(negedge clk) begin
    cyc++;
    phy_done = 1'b0;
    phy_err  = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        phy_done = 1'b1;
        phy_err  = (fail_left > 0);
        if (fail_left > 0) fail_left--;
        pend = 0;
      end else lat--;
    end
    if (own_req) own_seen = 1;
    if (phy_reset) last_rst = cyc;
    if (phy_start) begin
      starts++;
      if (starts == 1) first_gap = cyc - last_rst;
      else if ((cyc - last_rst) < min_gap) min_gap = cyc - last_rst;
      cap_wdata = phy_wdata;
      cap_lm1   = phy_len_m1;
      cap_cmd   = phy_cmd;
      cap_addr  = phy_addr;
      if (!hang) begin
        pend = 1;
        lat  = 3;
      end
    end
  end

  function automatic logic [127:0] keep_bytes(logic [127:0] d, int len);
    for (int i = 0; i < 16; i++) if (i >= len) d[8*i +: 8] = 8'h00;
    return d;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string rq, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
    chk(act === exp, rq, what, act, exp);
  endtask

  task automatic run(input logic [3:0] c, input logic [19:0] a,
                     input int len, input logic [127:0] wd);
    @(negedge clk);
    starts = 0; first_gap = -1; min_gap = 1000000; own_seen = 0;
    req_valid = 1'b1; req_cmd = c; req_addr = a;
    req_len = 5'(len); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    got_cyc = 1;
    while (!done && got_cyc < 5000) begin
      @(negedge clk);
      got_cyc++;
    end
    got_res   = result;
    got_rdata = rdata;
    @(negedge clk);
    done_long = done | own_req;
    pend = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nchecks++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    logic [127:0] wd, prev;
    void'($urandom(32'd2718));
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0;
    req_len = '0; req_wdata = '0; phy_busy = 1'b0; sink_present = 1'b1;
    grant_en = 1'b1; phy_rdata = '0; phy_done = 1'b0; phy_err = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_eq("R1", "done in reset", 128'(done), 128'(0));
    chk_eq("R1", "own_req in reset", 128'(own_req), 128'(0));
    chk_eq("R1", "phy pulses in reset", 128'({phy_start, phy_reset}), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R1", "rdata after reset", rdata, 128'(0));
    chk_eq("R1", "done after reset", 128'(done), 128'(0));

    // write, full length
    wd = {$urandom, $urandom, $urandom, $urandom};
    prev = rdata;
    run(4'h8, 20'h00100, 16, wd);
    chk_eq("R8", "write ok result", 128'(got_res), 128'(0));
    chk_eq("R5", "wdata len16", cap_wdata, wd);
    chk_eq("R5", "len_m1 len16", 128'(cap_lm1), 128'(15));
    chk_eq("R5", "cmd/addr", 128'({cap_cmd, cap_addr}), 128'({4'h8, 20'h00100}));
    chk_eq("R7", "first attempt gap", 128'(first_gap), 128'(1));
    chk_eq("R6", "write keeps rdata", got_rdata, prev);
    chk_eq("R11", "done single and released", 128'(done_long), 128'(0));

    // write, one byte
    run(4'h0, 20'h00200, 1, wd);
    chk_eq("R5", "wdata len1", cap_wdata, keep_bytes(wd, 1));
    chk_eq("R5", "len_m1 len1", 128'(cap_lm1), 128'(0));

    // read, five bytes
    phy_rdata = {$urandom, $urandom, $urandom, $urandom};
    run(4'h9, 20'h00202, 5, wd);
    chk_eq("R8", "read ok result", 128'(got_res), 128'(0));
    chk_eq("R6", "read data len5", got_rdata, keep_bytes(phy_rdata, 5));
    chk_eq("R6", "read carries no payload", cap_wdata, 128'(0));

    // two failures then success
    fail_left = 2;
    run(4'h8, 20'h00300, 4, wd);
    chk_eq("R9", "retry then ok", 128'(got_res), 128'(0));
    chk_eq("R9", "attempts with two errors", 128'(starts), 128'(3));
    chk(min_gap >= GAP * CPU, "R7", "retry gap", 128'(min_gap), 128'(GAP * CPU));

    // every attempt fails
    fail_left = 1000;
    run(4'h8, 20'h00300, 4, wd);
    fail_left = 0;
    chk_eq("R9", "exhausted result", 128'(got_res), 128'(3));
    chk_eq("R9", "attempt count", 128'(starts), 128'(TRIES));

    // PHY never answers
    hang = 1;
    run(4'h9, 20'h00400, 2, wd);
    hang = 0;
    chk_eq("R10", "request timeout result", 128'(got_res), 128'(3));
    chk_eq("R10", "no retry after timeout", 128'(starts), 128'(1));
    chk(got_cyc >= REQ * CPU && got_cyc <= REQ * CPU + 12, "R10",
        "request timeout latency", 128'(got_cyc), 128'(REQ * CPU + 7));

    // channel stays busy
    phy_busy = 1'b1;
    run(4'h8, 20'h00500, 3, wd);
    phy_busy = 1'b0;
    chk_eq("R2", "busy result", 128'(got_res), 128'(1));
    chk_eq("R2", "no ownership or start", 128'({own_seen, 8'(starts)}), 128'(0));
    chk(got_cyc >= IDLE * CPU && got_cyc <= IDLE * CPU + 6, "R2",
        "idle timeout latency", 128'(got_cyc), 128'(IDLE * CPU + 2));

    // grant never arrives
    grant_en = 1'b0;
    run(4'h8, 20'h00600, 3, wd);
    grant_en = 1'b1;
    chk_eq("R3", "grant timeout result", 128'(got_res), 128'(1));
    chk_eq("R3", "ownership requested", 128'(own_seen), 128'(1));
    chk_eq("R3", "released, no start", 128'({done_long, 8'(starts)}), 128'(0));

    // no sink
    sink_present = 1'b0;
    run(4'h9, 20'h00700, 3, wd);
    sink_present = 1'b1;
    chk_eq("R4", "no sink result", 128'(got_res), 128'(2));
    chk_eq("R4", "no start without sink", 128'(starts), 128'(0));

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [3:0] c;
      int len, fl;
      c  = 4'($urandom_range(0, 15));
      len = $urandom_range(1, 16);
      fl = $urandom_range(0, 2);
      wd = {$urandom, $urandom, $urandom, $urandom};
      phy_rdata = {$urandom, $urandom, $urandom, $urandom};
      prev = rdata;
      fail_left = fl;
      run(c, 20'($urandom), len, wd);
      chk_eq("R8", "random result", 128'(got_res), 128'(0));
      chk_eq("R9", "random attempts", 128'(starts), 128'(fl + 1));
      chk_eq("R5", "random len_m1", 128'(cap_lm1), 128'(len - 1));
      if (c[0]) begin
        chk_eq("R6", "random read data", got_rdata, keep_bytes(phy_rdata, len));
        chk_eq("R6", "random read no payload", cap_wdata, 128'(0));
      end else begin
        chk_eq("R5", "random write data", cap_wdata, keep_bytes(wd, len));
        chk_eq("R6", "random write keeps rdata", got_rdata, prev);
      end
      chk_eq("R11", "random done single", 128'(done_long), 128'(0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule